// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns a single-word request port into the command stream of a four-bank, 16-bit synchronous DRAM. Each request is one read or one write. The block opens the row with an ACTIVE command and waits the row-to-column delay. It then issues one READ or WRITE with the auto-precharge bit set, so no row stays open after an access. Read data is captured from the data bus after the CAS latency selected at initialisation, and it is returned with a one-cycle response pulse.

After reset the block runs its power-up sequence. It waits a programmable delay, precharges all banks, issues two auto refreshes and loads the mode register. Only then does it accept requests. From that point an interval timer keeps count of the refreshes owed, so that the configured number of refreshes fits in each retention window. An owed refresh is issued before any new access starts. Debt that builds up while an access is in progress is kept in the counter and is not lost.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (0111), and `req_ready`, `init_done` and `rsp_valid` are low.
- R2: After reset the first four commands are: PRECHARGE (0010) with A10 high, no earlier than INIT_CYCLES cycles after reset; then AUTO REFRESH (0001) twice; then LOAD MODE (0000). The mode word carries the CAS latency in A[6:4] and zero in A[3:0], which means burst length one and sequential order.
- R3: `req_ready` stays low and no ACTIVE (0011) is issued until LOAD MODE has gone out. A request held valid during initialisation is served only after that.
- R4: An accepted request `req_addr` = {bank, row, column} (column in bits [COL_W-1:0], row above it, bank at the top) produces ACTIVE with `sd_ba` = bank and `sd_a` = row. At least T_RCD cycles later it produces READ (0101) or WRITE (0100) on the same bank, with `sd_a[COL_W-1:0]` = column and `sd_a[10]` high. Write data is on `sd_dq_out` with `sd_dq_oe` high in the WRITE command cycle.
- R5: `cas_lat3` is sampled when LOAD MODE is issued: 0 selects a latency of 2 and 1 selects 3. `rsp_valid` pulses for one cycle exactly latency+1 cycles after READ appears on the pins. `rsp_rdata` carries the word the device drove, so a write followed by a read returns the written word.
- R6: Once `init_done` is high, one AUTO REFRESH is issued for every REF_WINDOW/REF_COUNT cycles, both when the port is idle and when it is loaded back to back.
- R7: A refresh that is owed is issued before the next ACTIVE, and `req_ready` stays low while any refresh is owed. AUTO REFRESH is never issued while a row is open.
- R8: Every command lasts one cycle and is followed by at least one NOP. After AUTO REFRESH, at least T_RFC cycles pass before the next ACTIVE or refresh. After an auto-precharging access, at least T_RP cycles pass before the next ACTIVE or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat3 | input | 1 | CAS latency choice: 0 = 2 clocks, 1 = 3 clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle where both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | DATA_W | Read word |
| init_done | output | 1 | Power-up sequence complete |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_a | output | ROW_W | Row / column / mode address |
| sd_dq_out | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from the device |

## Verification
The bench targets four corner cases. Read capture is checked at both latencies: a pipeline tap one stage off would return stale bus data, or pulse a cycle early or late. Refresh counts are measured over several intervals, both idle and under back-to-back traffic. A design that dropped refresh debt during accesses, or refreshed with a row open, would fall short of the count or trip the open-row check. A request is held valid across the whole power-up sequence to catch ACTIVE issued before LOAD MODE. Every gap between commands is checked against T_RCD, T_RP and T_RFC, which catches any wait counter that is off by one.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 976,
  parameter int DEBT_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

  logic [CNT_W-1:0]  tick_cnt_q;
  logic [DEBT_W-1:0] debt_q;
  logic              tick;

  assign tick    = enable && (tick_cnt_q == CNT_W'(INTERVAL - 1));
  assign pending = (debt_q != '0);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tick_cnt_q <= '0;
    end else if (tick) begin
      tick_cnt_q <= '0;
    end else begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
    end else begin
      case ({tick, ack && pending})
        2'b10:   if (debt_q != DEBT_MAX) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int DATA_W = 16,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl3,
  input  logic              rd_on_pins,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [MAX_CL-1:0] stage_q;
  logic              tap;

  assign tap = cl3 ? stage_q[MAX_CL-1] : stage_q[MAX_CL-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      stage_q   <= {stage_q[MAX_CL-2:0], rd_on_pins};
      rsp_valid <= tap;
      if (tap) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdr_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 16,
  parameter int INIT_CYCLES = 12500,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 9,
  parameter int T_MRD       = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cas_lat3,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  input  logic                            ref_pending,
  output logic                            req_ready,
  output logic                            ref_ack,
  output logic                            init_done,
  output logic                            cl3,
  output sdr_cmd_e                        cmd,
  output logic [BANK_W-1:0]               ba,
  output logic [ROW_W-1:0]                a,
  output logic [DATA_W-1:0]               dq_out,
  output logic                            dq_oe
);
  localparam int CNT_W   = $clog2(INIT_CYCLES + T_RFC + T_RCD + T_RP + T_MRD + 8);
  localparam int ROW_LSB = COL_W;
  localparam int BA_LSB  = COL_W + ROW_W;
  localparam int T_DONE  = T_RP + 3;

  typedef enum logic [2:0] {
    ST_POWERUP, ST_PRE_ALL, ST_INIT_REF, ST_MODE, ST_IDLE, ST_ACCESS, ST_WAIT
  } st_e;

  st_e               st_q, ret_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              second_ref_q;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (st_q == ST_IDLE) && !ref_pending;
  assign ref_ack   = (st_q == ST_IDLE) && ref_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_POWERUP;
      ret_q        <= ST_IDLE;
      cnt_q        <= CNT_W'(INIT_CYCLES);
      second_ref_q <= 1'b0;
      init_done    <= 1'b0;
      cl3          <= 1'b0;
      cmd          <= CMD_NOP;
      ba           <= '0;
      a            <= '0;
      dq_out       <= '0;
      dq_oe        <= 1'b0;
      wr_q         <= 1'b0;
      col_q        <= '0;
      wdata_q      <= '0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      case (st_q)
        ST_POWERUP: begin
          if (cnt_q == '0) st_q <= ST_PRE_ALL;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_PRE_ALL: begin
          cmd   <= CMD_PRE;
          a     <= '0;
          a[10] <= 1'b1;
          cnt_q <= CNT_W'(T_RP - 1);
          ret_q <= ST_INIT_REF;
          st_q  <= ST_WAIT;
        end
        ST_INIT_REF: begin
          cmd          <= CMD_REF;
          a            <= '0;
          second_ref_q <= 1'b1;
          cnt_q        <= CNT_W'(T_RFC - 1);
          ret_q        <= second_ref_q ? ST_MODE : ST_INIT_REF;
          st_q         <= ST_WAIT;
        end
        ST_MODE: begin
          cmd       <= CMD_MODE;
          ba        <= '0;
          a         <= '0;
          a[6:4]    <= cas_lat3 ? 3'b011 : 3'b010;
          cl3       <= cas_lat3;
          init_done <= 1'b1;
          cnt_q     <= CNT_W'(T_MRD - 1);
          ret_q     <= ST_IDLE;
          st_q      <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd   <= CMD_REF;
            cnt_q <= CNT_W'(T_RFC - 1);
            ret_q <= ST_IDLE;
            st_q  <= ST_WAIT;
          end else if (req_valid) begin
            cmd     <= CMD_ACT;
            ba      <= req_addr[BA_LSB +: BANK_W];
            a       <= req_addr[ROW_LSB +: ROW_W];
            wr_q    <= req_write;
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            cnt_q   <= CNT_W'(T_RCD - 1);
            ret_q   <= ST_ACCESS;
            st_q    <= ST_WAIT;
          end
        end
        ST_ACCESS: begin
          cmd              <= wr_q ? CMD_WR : CMD_RD;
          a                <= '0;
          a[COL_W-1:0]     <= col_q;
          a[10]            <= 1'b1;
          dq_out           <= wdata_q;
          dq_oe            <= wr_q;
          cnt_q            <= CNT_W'(T_DONE);
          ret_q            <= ST_IDLE;
          st_q             <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) st_q <= ret_q;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdr_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 16,
  parameter int INIT_CYCLES = 12500,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 9,
  parameter int REF_WINDOW  = 8000000,
  parameter int REF_COUNT   = 8192
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cas_lat3,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          init_done,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_a,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int REF_INTERVAL = REF_WINDOW / REF_COUNT;

  sdr_cmd_e cmd;
  logic     ref_pending, ref_ack, cl3;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL), .DEBT_W(3)) u_refresh (
    .clk(clk), .rst(rst), .enable(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdr_cmd_fsm #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .INIT_CYCLES(INIT_CYCLES), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(2)
  ) u_fsm (
    .clk(clk), .rst(rst), .cas_lat3(cas_lat3),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ref_pending(ref_pending),
    .req_ready(req_ready), .ref_ack(ref_ack), .init_done(init_done), .cl3(cl3),
    .cmd(cmd), .ba(sd_ba), .a(sd_a), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
  );

  sdr_rd_capture #(.DATA_W(DATA_W), .MAX_CL(3)) u_rdcap (
    .clk(clk), .rst(rst), .cl3(cl3), .rd_on_pins(cmd == CMD_RD),
    .dq_in(sd_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_a,
  input logic             req_ready,
  input logic             init_done,
  input logic             rsp_valid
);
  logic [3:0] pins;
  logic is_act, is_rw, is_rd, is_nop;
  assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_rw  = is_rd || (pins == 4'b0100);
  assign is_nop = (pins == 4'b0111);

  AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done); // R3
  AST_NO_ACT_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
    is_act |-> init_done); // R3
  AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
    is_rw |-> sd_a[10]); // R4
  AST_SINGLE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst)
    !is_nop |=> is_nop); // R8
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(is_rd, 3) || $past(is_rd, 4))); // R5
endmodule

bind sdram_cmd_ctrl sdr_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a(sd_a),
  .req_ready(req_ready), .init_done(init_done), .rsp_valid(rsp_valid)
);

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 9, DATA_W = 16;
  localparam int INIT_CYCLES = 20, T_RCD = 2, T_RP = 2, T_RFC = 6;
  localparam int REF_COUNT = 8192, INTERVAL = 80, REF_WINDOW = REF_COUNT * INTERVAL;
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst = 1, cas_lat3 = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, sd_dq_in = '0;
  logic req_ready, rsp_valid, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [DATA_W-1:0] rsp_rdata, sd_dq_out;
  logic [BANK_W-1:0] sd_ba;
  logic [ROW_W-1:0] sd_a;

  always #4 clk = ~clk;

  sdram_cmd_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .INIT_CYCLES(INIT_CYCLES), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .REF_WINDOW(REF_WINDOW), .REF_COUNT(REF_COUNT)) dut (
    .clk(clk), .rst(rst), .cas_lat3(cas_lat3), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- device stub ----------------
  logic [DATA_W-1:0] mem [0:255];
  logic [ROW_W-1:0] open_row [0:3];
  int rd_cnt = 0;
  logic [DATA_W-1:0] rd_dat = '0;
  always @(posedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rd_cnt == 1) sd_dq_in <= rd_dat;
    if (!rst && c == ACT) open_row[sd_ba] <= sd_a;
    if (!rst && c == WR) mem[{sd_ba, open_row[sd_ba][1:0], sd_a[3:0]}] <= sd_dq_out;
    if (!rst && c == RD) begin
      rd_dat <= mem[{sd_ba, open_row[sd_ba][1:0], sd_a[3:0]}];
      rd_cnt <= cas_lat3 ? 2 : 1;
    end else if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
  end

  // ---------------- pin monitor ----------------
  int cyc, nlog, n_ref, last_act, last_ref, last_rw, last_rd, rsp_cyc;
  int err_rcd, err_rfc, err_rp, err_open, err_init, err_b2b, err_ap;
  logic [3:0] log_cmd [0:7];
  logic [ROW_W-1:0] log_a [0:7];
  int log_cyc [0:7];
  bit bank_open [0:3];
  logic [3:0] prev_c;
  logic [BANK_W-1:0] act_ba;
  logic [ROW_W-1:0] act_row, rw_a;
  logic [DATA_W-1:0] wr_dq, rsp_d;
  logic wr_oe;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst) begin
      cyc = 0; nlog = 0; n_ref = 0; last_act = -1000; last_ref = -1000; last_rw = -1000;
      last_rd = -1000; rsp_cyc = -1; err_rcd = 0; err_rfc = 0; err_rp = 0; err_open = 0;
      err_init = 0; err_b2b = 0; err_ap = 0; prev_c = NOP;
      for (int i = 0; i < 4; i++) bank_open[i] = 0;
    end else begin
      cyc++;
      if (c != NOP && nlog < 8) begin
        log_cmd[nlog] = c; log_a[nlog] = sd_a; log_cyc[nlog] = cyc; nlog++;
      end
      if (c != NOP && prev_c != NOP) err_b2b++;
      if (req_ready && !init_done) err_init++;
      case (c)
        ACT: begin
          if (!init_done) err_init++;
          if (cyc - last_ref < T_RFC) err_rfc++;
          if (cyc - last_rw < T_RP) err_rp++;
          bank_open[sd_ba] = 1; last_act = cyc; act_ba = sd_ba; act_row = sd_a;
        end
        RD, WR: begin
          if (cyc - last_act < T_RCD) err_rcd++;
          if (!sd_a[10]) err_ap++;
          bank_open[sd_ba] = 0; last_rw = cyc; rw_a = sd_a;
          wr_dq = sd_dq_out; wr_oe = sd_dq_oe;
          if (c == RD) last_rd = cyc;
        end
        REF: begin
          if (bank_open[0] || bank_open[1] || bank_open[2] || bank_open[3]) err_open++;
          if (cyc - last_ref < T_RFC) err_rfc++;
          if (cyc - last_rw < T_RP) err_rp++;
          n_ref++; last_ref = cyc;
        end
        default: ;
      endcase
      if (rsp_valid) begin rsp_cyc = cyc; rsp_d = rsp_rdata; end
      prev_c = c;
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic do_reset(input bit cl3);
    rst = 1; cas_lat3 = cl3; req_valid = 0;
    repeat (4) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_init();
    int t = 0;
    while (!init_done && t < 500) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] adr, input logic [DATA_W-1:0] d);
    int t = 0;
    @(negedge clk);
    while (!req_ready && t < 500) begin @(negedge clk); t++; end
    req_valid = 1; req_write = wr; req_addr = adr; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic read_check(input logic [AW-1:0] adr, input logic [DATA_W-1:0] exp, input int cl);
    int t = 0;
    rsp_cyc = -1;
    issue(0, adr, 0);
    while (rsp_cyc < 0 && t < 100) begin @(negedge clk); t++; end
    chk(rsp_d === exp, "R5 read data", rsp_d, exp);
    chk(rsp_cyc - last_rd == cl + 1, "R5 response latency", rsp_cyc - last_rd, cl + 1);
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 pins NOP in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk(!req_ready && !init_done && !rsp_valid, "R1 outputs low in reset",
        {req_ready, init_done, rsp_valid}, 0);
    rst = 0; @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 pins NOP after reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
  endtask

  task automatic t_init(input bit cl3);
    int t = 0;
    rst = 1; cas_lat3 = cl3;
    req_valid = 1; req_write = 1; req_addr = {2'd3, 13'd1, 9'd5}; req_wdata = 16'hC0DE;
    repeat (4) @(negedge clk);
    rst = 0;
    while (!(req_ready && init_done) && t < 500) begin @(negedge clk); t++; end
    @(negedge clk); req_valid = 0;
    repeat (10) @(negedge clk);
    chk(log_cmd[0] == PRE && log_a[0][10], "R2 first cmd PRE all", log_cmd[0], PRE);
    chk(log_cyc[0] >= INIT_CYCLES, "R2 power-up delay", log_cyc[0], INIT_CYCLES);
    chk(log_cmd[1] == REF && log_cmd[2] == REF, "R2 two refreshes",
        {log_cmd[1], log_cmd[2]}, {REF, REF});
    chk(log_cmd[3] == MRS, "R2 load mode", log_cmd[3], MRS);
    chk(log_a[3][6:0] == {cl3 ? 3'b011 : 3'b010, 4'b0000}, "R2 mode word",
        log_a[3][6:0], {cl3 ? 3'b011 : 3'b010, 4'b0000});
    chk(log_cmd[4] == ACT, "R3 held request served after init", log_cmd[4], ACT);
    chk(err_init == 0, "R3 no ready/ACT before init", err_init, 0);
  endtask

  task automatic t_access();
    issue(1, {2'd2, 13'h1A5B, 9'h1F3}, 16'hBEEF);
    repeat (12) @(negedge clk);
    chk(act_ba == 2'd2 && act_row == 13'h1A5B, "R4 ACT bank/row",
        {act_ba, act_row}, {2'd2, 13'h1A5B});
    chk(rw_a[8:0] == 9'h1F3 && rw_a[10], "R4 column and A10", rw_a, {1'b1, 1'b0, 9'h1F3});
    chk(wr_oe && wr_dq == 16'hBEEF, "R4 write data on bus", wr_dq, 16'hBEEF);
    chk(err_rcd == 0 && err_ap == 0, "R4 tRCD and auto-precharge", err_rcd + err_ap, 0);
  endtask

  task automatic t_roundtrip(input int cl);
    for (int i = 0; i < 4; i++)
      issue(1, {2'(i), 13'(i), 9'(i * 3)}, 16'(16'h1111 * (i + 1) + cl));
    for (int i = 0; i < 4; i++)
      read_check({2'(i), 13'(i), 9'(i * 3)}, 16'(16'h1111 * (i + 1) + cl), cl);
  endtask

  task automatic t_refresh_idle();
    int r0;
    r0 = n_ref;
    repeat (8 * INTERVAL) @(negedge clk);
    chk(n_ref - r0 >= 7 && n_ref - r0 <= 9, "R6 idle refresh rate", n_ref - r0, 8);
  endtask

  task automatic t_refresh_load();
    int r0, c0;
    r0 = n_ref; c0 = cyc;
    while (cyc - c0 < 8 * INTERVAL) issue(1, {2'(cyc), 13'd7, 9'(cyc)}, 16'(cyc));
    chk(n_ref - r0 >= 7 && n_ref - r0 <= 9, "R6 loaded refresh rate", n_ref - r0, 8);
    chk(err_open == 0, "R7 no refresh with open row", err_open, 0);
  endtask

  task automatic t_timing();
    chk(err_rfc == 0, "R8 tRFC gap", err_rfc, 0);
    chk(err_rp == 0, "R8 tRP gap", err_rp, 0);
    chk(err_b2b == 0, "R8 single-cycle commands", err_b2b, 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    do_reset(0);
    t_reset();
    t_init(0);
    t_access();
    t_roundtrip(2);
    t_refresh_idle();
    t_refresh_load();
    t_timing();
    t_init(1);
    t_roundtrip(3);
    t_refresh_load();
    t_timing();
    report();
  end
endmodule